// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Software Acknowledge

This block receives asynchronous serial frames for a memory-mapped peripheral. It runs from the system clock. A one-cycle `tick` pulse arrives sixteen times per bit period. The serial line passes through a two-flop synchroniser. A falling edge starts a frame, and the line must still be LOW at the middle of the start bit for the frame to be accepted. The block then samples eight data bits, least significant bit first, each in the middle of its bit period. An optional parity bit follows, then one stop bit. When the stop bit has been sampled, the assembled byte is written to the receive buffer.

Software consumes each byte and confirms it with a one-cycle acknowledge pulse. A byte that completes while the previous one is still unacknowledged counts as an overrun rather than a normal completion. Three sticky error flags report parity, overrun and framing faults. A completion flag and a summary error flag are cleared by write-one-to-clear pulses. Each of these two flags drives an interrupt output through its own enable. Dropping the receive-enable level aborts any frame in progress and clears the three error flags.

Top module: `uart_rx_ack`

## Requirements
- R1: After reset, `rx_data` is 0 and every flag and interrupt output is 0.
- R2: With `rx_enable` high, a frame is accepted and its byte is written to `rx_data`. A frame is a LOW start bit, 8 data bits sent least significant bit first, the parity bit if `parity_en` is set, and a stop bit, each lasting 16 ticks. If the previous byte was acknowledged, `done_flag` is set.
- R3: A LOW pulse on `serial_in` that has returned HIGH by the middle of the start bit is ignored. `rx_data` and all flags stay unchanged.
- R4: When `parity_en` is 1, a parity bit follows the data bits. The expected parity bit is the XOR of the data bits for even parity (`parity_odd`=0), and its inverse for odd parity (`parity_odd`=1). A mismatch sets `par_err` and `err_flag`. When `parity_en` is 0, no parity bit is expected.
- R5: A stop bit sampled LOW sets `frm_err` and `err_flag`. The byte is still delivered to `rx_data`.
- R6: A frame that completes while the previous byte is unacknowledged sets `ovr_err` and `err_flag`, and it does not set `done_flag`. The new byte still overwrites `rx_data`. An acknowledge in the completion cycle counts as given.
- R7: While `rx_enable` is 0, any frame in progress is abandoned and `par_err`, `ovr_err` and `frm_err` are cleared. `done_flag`, `err_flag` and `rx_data` are kept.
- R8: A `clr_done` pulse clears `done_flag` and a `clr_err` pulse clears `err_flag`. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_rx` is high exactly when both `done_flag` and `ie_rx` are high. `irq_err` is high exactly when both `err_flag` and `ie_err` are high.
- R10: A frame sent while `rx_enable` is 0 is ignored. `rx_data`, `done_flag` and `err_flag` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idles HIGH |
| rx_enable | input | 1 | Receive enable level; LOW aborts the frame in progress and clears the error flags |
| parity_en | input | 1 | A parity bit is expected after the data bits |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| ie_rx | input | 1 | Enable for the completion interrupt |
| ie_err | input | 1 | Enable for the error interrupt |
| ack_strobe | input | 1 | One-cycle pulse: software has consumed the buffered byte |
| clr_done | input | 1 | One-cycle pulse that clears `done_flag` |
| clr_err | input | 1 | One-cycle pulse that clears `err_flag` |
| rx_data | output | DATA_BITS | Receive buffer |
| done_flag | output | 1 | A byte completed without overrun |
| err_flag | output | 1 | Summary error interrupt flag |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |
| irq_rx | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The random frames vary the byte, the parity mode and whether a parity bit is present. Their parity and stop bits are sometimes corrupted. The acknowledge, clear and interrupt-enable inputs are also randomised, so each completion lands on a different mix of prior flag states. This separates faults in bit order and sampling phase from faults in the set, clear and priority logic of the flags. Directed frames cover the remaining cases. A short start glitch separates the mid-bit check from plain edge detection. A back-to-back frame without acknowledge tests overrun suppression of the completion flag. An abort in mid-frame and a frame sent while disabled show which state the enable clears and which it keeps.

// File: rtl/uart_rx_ack.sv
module uart_rx_ack #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 serial_in,
  input  logic                 rx_enable,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  input  logic                 ie_rx,
  input  logic                 ie_err,
  input  logic                 ack_strobe,
  input  logic                 clr_done,
  input  logic                 clr_err,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 done_flag,
  output logic                 err_flag,
  output logic                 par_err,
  output logic                 ovr_err,
  output logic                 frm_err,
  output logic                 irq_rx,
  output logic                 irq_err
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                  st;
  logic [1:0]           sync;
  logic [CW-1:0]        ph;
  logic [BW-1:0]        nbit;
  logic [DATA_BITS-1:0] shreg;
  logic                 pbit;
  logic                 buf_full;

  wire rx_s     = sync[1];
  wire mid_hit  = tick && (ph == CW'(MID));
  wire end_hit  = tick && (ph == CW'(OVS - 1));
  wire finish   = rx_enable && (st == S_STOP) && end_hit;
  wire stop_bad = !rx_s;
  wire par_bad  = parity_en && (pbit != (^shreg ^ parity_odd));
  wire overrun  = buf_full && !ack_strobe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], serial_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= '0;
      nbit  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!rx_enable) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:
          if (tick && !rx_s) begin
            st <= S_START;
            ph <= '0;
          end
        S_START:
          if (mid_hit) begin
            ph   <= '0;
            nbit <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else if (tick) ph <= ph + 1'b1;
        S_DATA:
          if (end_hit) begin
            ph    <= '0;
            shreg <= {rx_s, shreg[DATA_BITS-1:1]};
            nbit  <= nbit + 1'b1;
            if (nbit == BW'(DATA_BITS - 1)) st <= parity_en ? S_PAR : S_STOP;
          end else if (tick) ph <= ph + 1'b1;
        S_PAR:
          if (end_hit) begin
            ph   <= '0;
            pbit <= rx_s;
            st   <= S_STOP;
          end else if (tick) ph <= ph + 1'b1;
        S_STOP:
          if (end_hit) begin
            ph <= '0;
            st <= S_IDLE;
          end else if (tick) ph <= ph + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      buf_full  <= 1'b0;
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
      par_err   <= 1'b0;
      ovr_err   <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      if (finish) rx_data <= shreg;

      if (finish)          buf_full <= 1'b1;
      else if (ack_strobe) buf_full <= 1'b0;

      if (finish && !overrun) done_flag <= 1'b1;
      else if (clr_done)      done_flag <= 1'b0;

      if (finish && (stop_bad || par_bad || overrun)) err_flag <= 1'b1;
      else if (clr_err)                               err_flag <= 1'b0;

      if (!rx_enable) begin
        par_err <= 1'b0;
        ovr_err <= 1'b0;
        frm_err <= 1'b0;
      end else if (finish) begin
        if (par_bad)  par_err <= 1'b1;
        if (overrun)  ovr_err <= 1'b1;
        if (stop_bad) frm_err <= 1'b1;
      end
    end
  end

  assign irq_rx  = done_flag & ie_rx;
  assign irq_err = err_flag & ie_err;

  // R6
  ovr_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> !$rose(done_flag));

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!par_err && !ovr_err && !frm_err && st == S_IDLE));

  // R5
  err_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frm_err) || $rose(par_err) || $rose(ovr_err)) |-> err_flag);

  // R2
  data_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> (done_flag || ovr_err));

  // R10
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !done_flag) |=> !$rose(done_flag));
endmodule

// File: tb/uart_rx_ack_test.sv
module uart_rx_ack_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick;
  logic serial_in = 1'b1, rx_enable = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic ie_rx = 1'b0, ie_err = 1'b0, ack_strobe = 1'b0, clr_done = 1'b0, clr_err = 1'b0;
  logic [7:0] rx_data;
  logic done_flag, err_flag, par_err, ovr_err, frm_err, irq_rx, irq_err;

  int checks = 0, failures = 0;
  logic [7:0] e_data = 8'h00;
  logic e_full = 0, e_done = 0, e_err = 0, e_pe = 0, e_oe = 0, e_fe = 0;

  uart_rx_ack uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .serial_in(serial_in),
    .rx_enable(rx_enable), .parity_en(parity_en), .parity_odd(parity_odd),
    .ie_rx(ie_rx), .ie_err(ie_err), .ack_strobe(ack_strobe),
    .clr_done(clr_done), .clr_err(clr_err), .rx_data(rx_data),
    .done_flag(done_flag), .err_flag(err_flag), .par_err(par_err),
    .ovr_err(ovr_err), .frm_err(frm_err), .irq_rx(irq_rx), .irq_err(irq_err));

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0] tdiv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tdiv <= '0;
      tick <= 1'b0;
    end else begin
      tdiv <= tdiv + 1'b1;
      tick <= (tdiv == 2'd3);
    end

  function automatic logic good_parity(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "rx_data", rx_data, e_data);
    chk(req, "done_flag", done_flag, e_done);
    chk(req, "err_flag", err_flag, e_err);
    chk(req, "par_err", par_err, e_pe);
    chk(req, "ovr_err", ovr_err, e_oe);
    chk(req, "frm_err", frm_err, e_fe);
    chk("R9", "irq_rx", irq_rx, e_done & ie_rx);
    chk("R9", "irq_err", irq_err, e_err & ie_err);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen, input logic pb, input logic stopv);
    serial_in = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      serial_in = d[i];
      wait_ticks(16);
    end
    if (pen) begin
      serial_in = pb;
      wait_ticks(16);
    end
    serial_in = stopv;
    if (stopv) wait_ticks(16);
    else begin
      wait_ticks(12);
      serial_in = 1'b1;
      wait_ticks(12);
    end
    serial_in = 1'b1;
    wait_ticks(4);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic pen, input logic odd, input logic pb, input logic stopv);
    logic fe_n, pe_n, ov;
    parity_en  = pen;
    parity_odd = odd;
    send_frame(d, pen, pb, stopv);
    fe_n = !stopv;
    pe_n = pen && (pb != good_parity(d, odd));
    ov   = e_full;
    e_data = d;
    e_full = 1'b1;
    if (ov) e_oe = 1'b1; else e_done = 1'b1;
    if (fe_n) e_fe = 1'b1;
    if (pe_n) e_pe = 1'b1;
    if (fe_n || pe_n || ov) e_err = 1'b1;
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack_strobe = 1'b1;
    @(negedge clk) ack_strobe = 1'b0;
    e_full = 1'b0;
  endtask

  task automatic pulse_clr(input logic cd, input logic ce);
    @(negedge clk) begin clr_done = cd; clr_err = ce; end
    @(negedge clk) begin clr_done = 1'b0; clr_err = 1'b0; end
    if (cd) e_done = 1'b0;
    if (ce) e_err = 1'b0;
  endtask

  task automatic set_enable(input logic en);
    @(negedge clk) rx_enable = en;
    repeat (3) @(negedge clk);
    if (!en) begin e_pe = 0; e_oe = 0; e_fe = 0; end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (5) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    ie_rx = 1'b1;
    ie_err = 1'b1;
    set_enable(1'b1);

    // R2 basic frame, LSB first
    rx_frame(8'hA5, 0, 0, 0, 1);
    check_all("R2");
    rx_frame(8'h01, 0, 0, 0, 1);   // overrun since no ack -> R6 covered later too
    check_all("R6");
    set_enable(1'b0);
    set_enable(1'b1);
    pulse_ack();
    pulse_clr(1, 1);
    check_all("R8");

    // R3 short start glitch
    serial_in = 1'b0;
    wait_ticks(4);
    serial_in = 1'b1;
    wait_ticks(40);
    check_all("R3");

    // R4 parity modes
    rx_frame(8'h3C, 1, 0, good_parity(8'h3C, 0), 1);
    check_all("R4");
    pulse_ack();
    rx_frame(8'h3D, 1, 0, ~good_parity(8'h3D, 0), 1);
    check_all("R4");
    pulse_ack();
    pulse_clr(1, 1);
    rx_frame(8'hC7, 1, 1, good_parity(8'hC7, 1), 1);
    check_all("R4");
    pulse_ack();
    rx_frame(8'h80, 1, 1, ~good_parity(8'h80, 1), 1);
    check_all("R4");
    pulse_ack();

    // R5 framing error
    rx_frame(8'h5A, 0, 0, 0, 0);
    check_all("R5");
    pulse_ack();

    // R7 disable clears error flags, keeps done/err/data
    set_enable(1'b0);
    check_all("R7");
    set_enable(1'b1);
    pulse_clr(1, 1);
    serial_in = 1'b0;
    wait_ticks(50);
    set_enable(1'b0);
    serial_in = 1'b1;
    set_enable(1'b1);
    wait_ticks(200);
    check_all("R7");

    // R6 overrun suppresses done
    rx_frame(8'h11, 0, 0, 0, 1);
    pulse_clr(1, 0);
    rx_frame(8'h22, 0, 0, 0, 1);
    check_all("R6");
    chk("R6", "done_after_overrun", done_flag, 1'b0);
    set_enable(1'b0);
    set_enable(1'b1);
    pulse_ack();

    // R8 each clear acts alone
    pulse_clr(1, 0);
    check_all("R8");
    pulse_clr(0, 1);
    check_all("R8");

    // R10 frame while disabled
    rx_frame(8'h99, 0, 0, 0, 1);
    pulse_ack();
    set_enable(1'b0);
    send_frame(8'h66, 0, 0, 1);
    set_enable(1'b1);
    check_all("R10");

    // R9 with enables off
    ie_rx = 1'b0;
    ie_err = 1'b0;
    @(negedge clk);
    check_all("R9");

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      logic pen, odd, pb, sv;
      d   = 8'($urandom);
      pen = 1'($urandom);
      odd = 1'($urandom);
      pb  = good_parity(d, odd) ^ (($urandom % 8) == 0);
      sv  = ($urandom % 10) != 0;
      ie_rx  = 1'($urandom);
      ie_err = 1'($urandom);
      rx_frame(d, pen, odd, pb, sv);
      check_all("R2");
      if (($urandom % 5) != 0) pulse_ack();
      if (($urandom % 3) == 0) pulse_clr(1'($urandom), 1'($urandom));
      if (($urandom % 6) == 0) begin
        set_enable(1'b0);
        set_enable(1'b1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule